// File: doc/BRIEF.md
# Channel Status Decoder

This block follows the channel status stream of one audio channel. One C bit arrives with each frame strobe, and the first frame of each 192-frame block is flagged. The block keeps only the bits it needs to decode. It runs an 8-bit CRC over the leading 184 bits and compares the result with the final byte of the block. When a block completes, it latches a small set of decoded fields. Six shared status pins show either those decoded fields or an error and frequency view, chosen by a select input. The frequency code comes from outside the block. The block does not measure frequency.

A separate block-position output stays high through the first 32 frames of every block and low for the rest. Downstream logic can use it to align its own framing. The decoded fields depend on bit 0 of the block. When bit 0 is 1 the block is professional, and when it is 0 the block is consumer. Each format gives some pins its own meaning. In consumer mode, the CRC pin carries a category-ignore flag instead.

Top module: `csd_decoder`

## Requirements
- R1: After the block-start frame is accepted, `blk_pos_o` reads 1. It stays 1 through frame index 31 and reads 0 from index 32 through 191. It is 0 whenever the decoder is not locked to a block.
- R2: The check value is computed over frames 0..183 in arrival order. It uses an 8-bit shift register seeded with 0xFF and the polynomial x^8+x^4+x^3+x^2+1. For each bit, the feedback is register bit 7 XOR the incoming bit. The register shifts left, and when the feedback is 1 it is XORed with 0x1D. Frame 184+k must equal register bit k, for k = 0..7. On a mismatch, `stat_o[0]` reads 0 with select low, and `stat_o[5]` reads 0 with select high in professional mode.
- R3: A block-start flag that arrives while locked, at any index other than 0, is a misplaced boundary. It drives `stat_o[0]` and `stat_o[1]` (select low) to 0 at once. The decoder restarts at index 0.
- R4: A frame at index 0 that lacks the start flag is also a misplaced boundary. It drives `stat_o[0]` and `stat_o[1]` low, and the decoder drops lock, so `stat_o[2]` reads 0 with select low. While unlocked, frames without the start flag are ignored.
- R5: The decoded fields and the CRC result change only on the edge that accepts frame 191. The only other cause of change is a misplaced-boundary event, which changes the error flags alone.
- R6: With select high, `stat_o[2]` is the inverse of bit 9 (bit 1 of byte 1).
- R7: In consumer mode with select high, `stat_o[5]` is the category-ignore flag. The category is read from bits 8..14, in that order. The flag reads 0 when those bits are 0000000 or match 01100xx, and 1 otherwise.
- R8: With select high, `stat_o[0]` is bit 0 and `stat_o[1]` is bit 1. Pins `stat_o[3]` and `stat_o[4]` carry bits 6 and 7 in professional mode, and bits 2 and 3 in consumer mode.
- R9: With select low, `stat_o[4:3]` equals `freq_i` and `stat_o[5]` equals the latched bit 0. `stat_o[1]` is 0 after a misplaced boundary, and `stat_o[2]` is 1 while locked. A block that completes cleanly clears both error flags.
- R10: After reset, the latched bits are all 0 and both error flags are clear. The decoder is unlocked and `blk_pos_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe: a frame's C bit is valid |
| blk_start_i | input | 1 | Qualifies the strobe as the first frame of a block |
| cbit_i | input | 1 | Channel status bit of this frame |
| sel_i | input | 1 | 1: decoded fields, 0: error/frequency view |
| freq_i | input | 2 | Externally measured frequency class |
| stat_o | output | 6 | Shared status pins |
| blk_pos_o | output | 1 | High during the first 32 frames of a block |

## Verification
The bench sweeps all 128 consumer category codes, so a category-ignore decode that is off by one bit or uses the wrong bit order fails on its neighbouring codes. It also runs all 16 combinations of the professional field bits, so a missing inversion of bit 9 or a swapped pair of fields shows up at once. Each of the eight received check bits is flipped in turn, which catches a check compared in reversed bit order. Misplaced boundaries are tested in both forms, an early start and a missing start. Fields are probed in the middle of a block, where a design that updates early would show partial data.

// File: rtl/csd_pkg.sv
package csd_pkg;
    typedef struct packed {
        logic pro;       // bit 0
        logic f1;        // bit 1
        logic nb9;       // inverted bit 9
        logic f3;        // bit 6 or bit 2
        logic f4;        // bit 7 or bit 3
        logic cat_hit;   // consumer category to be ignored
        logic crc_bad;
        logic bnd_bad;
    } csd_flags_t;

    localparam csd_flags_t FLAGS_RST = '{pro: 1'b0, f1: 1'b0, nb9: 1'b1,
        f3: 1'b0, f4: 1'b0, cat_hit: 1'b1, crc_bad: 1'b0, bnd_bad: 1'b0};
endpackage

// File: rtl/csd_crc8.sv
module csd_crc8 #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h1D,
    parameter logic [W-1:0] INIT = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_d, crc_q, base;
    logic         fb;

    always_comb begin
        base  = load_i ? INIT : crc_q;
        fb    = base[W-1] ^ bit_i;
        crc_d = base;
        if (step_i) begin
            crc_d = {base[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/csd_frame_pos.sv
module csd_frame_pos #(
    parameter int FRAMES = 192,
    parameter int IDXW   = $clog2(FRAMES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_stb_i,
    input  logic            blk_start_i,
    output logic            accept_o,
    output logic [IDXW-1:0] idx_o,
    output logic            done_o,
    output logic            viol_o,
    output logic            sync_o,
    output logic [IDXW-1:0] last_o
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(FRAMES - 1);

    typedef struct packed {
        logic            sync;
        logic [IDXW-1:0] cnt;   // index expected next
        logic [IDXW-1:0] last;  // index of last accepted frame
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        accept_o = 1'b0;
        idx_o    = '0;
        viol_o   = 1'b0;
        if (frame_stb_i) begin
            if (blk_start_i) begin
                viol_o    = st_q.sync && (st_q.cnt != '0);
                accept_o  = 1'b1;
                st_d.sync = 1'b1;
                st_d.cnt  = IDXW'(1);
                st_d.last = '0;
            end else if (st_q.sync) begin
                if (st_q.cnt == '0) begin
                    viol_o    = 1'b1;
                    st_d.sync = 1'b0;
                end else begin
                    accept_o  = 1'b1;
                    idx_o     = st_q.cnt;
                    st_d.last = st_q.cnt;
                    st_d.cnt  = (st_q.cnt == LAST_IDX) ? '0 : st_q.cnt + 1'b1;
                end
            end
        end
        done_o = accept_o && (idx_o == LAST_IDX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign last_o = st_q.last;

    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt < IDXW'(FRAMES)) && (st_q.last < IDXW'(FRAMES)));

    // R3
    early_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb_i && blk_start_i && st_q.sync && st_q.cnt != '0)
        |=> (st_q.sync && st_q.last == '0));

    // R4
    missing_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb_i && !blk_start_i && st_q.sync && st_q.cnt == '0)
        |=> !st_q.sync);
endmodule

// File: rtl/csd_decoder.sv
module csd_decoder #(
    parameter int          FRAMES    = 192,
    parameter int          CRC_W     = 8,
    parameter logic [7:0]  CRC_POLY  = 8'h1D,
    parameter logic [7:0]  CRC_INIT  = 8'hFF,
    parameter int          POS_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_stb_i,
    input  logic       blk_start_i,
    input  logic       cbit_i,
    input  logic       sel_i,
    input  logic [1:0] freq_i,
    output logic [5:0] stat_o,
    output logic       blk_pos_o
);
    import csd_pkg::*;

    localparam int IDXW       = $clog2(FRAMES);
    localparam int CRC_END    = FRAMES - CRC_W;
    localparam int HDR_BITS   = 16;
    localparam int HW         = $clog2(HDR_BITS);
    localparam int TW         = $clog2(CRC_W);
    localparam int POS_FRAMES = POS_BYTES * 8;

    typedef struct packed {
        logic [HDR_BITS-1:0] hdr;
        logic [CRC_W-1:0]    tail;
        csd_flags_t          fl;
    } dec_t;

    dec_t            st_d, st_q;
    logic            accept, done, viol, sync;
    logic [IDXW-1:0] idx, last;
    logic [CRC_W-1:0] crc_calc, crc_rx;
    logic [HW-1:0]   hoff;
    logic [TW-1:0]   toff;
    logic [6:0]      cat;
    logic            cat_hit;

    csd_frame_pos #(.FRAMES(FRAMES), .IDXW(IDXW)) u_pos (
        .clk(clk), .rst_n(rst_n), .frame_stb_i(frame_stb_i),
        .blk_start_i(blk_start_i), .accept_o(accept), .idx_o(idx),
        .done_o(done), .viol_o(viol), .sync_o(sync), .last_o(last));

    csd_crc8 #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .load_i(accept && idx == '0),
        .step_i(accept && idx < IDXW'(CRC_END)),
        .bit_i(cbit_i), .crc_o(crc_calc));

    always_comb begin
        hoff    = HW'(idx);
        toff    = TW'(idx - IDXW'(CRC_END));
        crc_rx  = {cbit_i, st_q.tail[CRC_W-2:0]};
        cat     = st_q.hdr[14:8];
        cat_hit = (cat == 7'd0) ||
                  (!cat[0] && cat[1] && cat[2] && !cat[3] && !cat[4]);
        st_d    = st_q;
        if (accept && idx < IDXW'(HDR_BITS)) st_d.hdr[hoff] = cbit_i;
        if (accept && idx >= IDXW'(CRC_END)) st_d.tail[toff] = cbit_i;
        if (done) begin
            st_d.fl.pro     = st_q.hdr[0];
            st_d.fl.f1      = st_q.hdr[1];
            st_d.fl.nb9     = ~st_q.hdr[9];
            st_d.fl.f3      = st_q.hdr[0] ? st_q.hdr[6] : st_q.hdr[2];
            st_d.fl.f4      = st_q.hdr[0] ? st_q.hdr[7] : st_q.hdr[3];
            st_d.fl.cat_hit = cat_hit;
            st_d.fl.crc_bad = (crc_rx != crc_calc);
            st_d.fl.bnd_bad = 1'b0;
        end
        if (viol) begin
            st_d.fl.crc_bad = 1'b1;
            st_d.fl.bnd_bad = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hdr: '0, tail: '0, fl: FLAGS_RST};
        else        st_q <= st_d;
    end

    always_comb begin
        if (sel_i) begin
            stat_o = {st_q.fl.pro ? ~st_q.fl.crc_bad : ~st_q.fl.cat_hit,
                      st_q.fl.f4, st_q.fl.f3, st_q.fl.nb9,
                      st_q.fl.f1, st_q.fl.pro};
        end else begin
            stat_o = {st_q.fl.pro, freq_i, sync,
                      ~st_q.fl.bnd_bad, ~st_q.fl.crc_bad};
        end
        blk_pos_o = sync && (last < IDXW'(POS_FRAMES));
    end

    // R1
    blkpos_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_pos_o) |-> $past(frame_stb_i && blk_start_i));

    // R5
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> $stable({st_q.fl.pro, st_q.fl.f1, st_q.fl.nb9,
                                  st_q.fl.f3, st_q.fl.f4, st_q.fl.cat_hit}));

    // R3
    viol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (st_q.fl.bnd_bad && st_q.fl.crc_bad));
endmodule

// File: tb/csd_decoder_bench.sv
module csd_decoder_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0, start = 1'b0, cbit = 1'b0, sel = 1'b0;
    logic [1:0] freq = 2'd0;
    logic [5:0] stat;
    logic       blkpos;
    int         n_run = 0, n_fail = 0;
    bit         ended = 1'b0;

    always #2 clk = ~clk;

    csd_decoder u_csd_decoder (
        .clk(clk), .rst_n(rst_n), .frame_stb_i(stb), .blk_start_i(start),
        .cbit_i(cbit), .sel_i(sel), .freq_i(freq), .stat_o(stat),
        .blk_pos_o(blkpos));

    function automatic logic [191:0] seal(input logic [191:0] b);
        logic [191:0] r = b;
        logic [7:0]   c = 8'hFF;
        for (int i = 0; i < 184; i++) begin
            logic fb = c[7] ^ b[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h1D;
        end
        for (int k = 0; k < 8; k++) r[184+k] = c[k];
        return r;
    endfunction

    function automatic logic [191:0] rnd_block();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [5:0] exp_fields(input logic [191:0] b, input logic crcbad);
        logic pro = b[0];
        logic [6:0] cat = b[14:8];
        logic ign = (cat == 7'd0) ||
                    (!cat[0] && cat[1] && cat[2] && !cat[3] && !cat[4]);
        return {pro ? ~crcbad : ~ign,
                pro ? b[7] : b[3], pro ? b[6] : b[2], ~b[9], b[1], pro};
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic look(input logic s, output logic [6:0] v);
        sel = s;
        #1;
        v = {blkpos, stat};
    endtask

    task automatic frame(input logic b, input logic st);
        @(negedge clk);
        stb = 1'b1; start = st; cbit = b;
        @(negedge clk);
        stb = 1'b0; start = 1'b0;
    endtask

    task automatic send(input logic [191:0] b, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) frame(b[i], i == 0);
    endtask

    initial begin
        logic [6:0] v;
        logic [191:0] b, prev;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset view
        look(1'b1, v); chk("R10 fields", v, 7'b0_000100);
        look(1'b0, v); chk("R10 errview", v, 7'b0_000011);
        // R4 unsynced frames ignored
        for (int i = 0; i < 20; i++) frame(i[0], 1'b0);
        look(1'b0, v); chk("R4 ignore unsynced", v, 7'b0_000011);

        // R7 R6 R8 R1 R5: consumer category sweep
        prev = '0;
        for (int c = 0; c < 128; c++) begin
            b = rnd_block();
            b[0] = 1'b0;
            b[14:8] = c[6:0];
            b = seal(b);
            send(b, 0, 31);
            look(1'b1, v); chk("R1 high at 31", {v[6], 6'd0}, 7'b1_000000);
            if (c > 0) chk("R5 hold mid block", {1'b0, v[5:0]}, {1'b0, exp_fields(prev, 1'b0)});
            send(b, 32, 32);
            look(1'b1, v); chk("R1 low at 32", {v[6], 6'd0}, 7'b0_000000);
            send(b, 33, 191);
            look(1'b1, v); chk("R7 R6 R8 consumer", v, {1'b0, exp_fields(b, 1'b0)});
            prev = b;
        end

        // R8 R6 R9 R2: professional field sweep
        for (int p = 0; p < 16; p++) begin
            b = rnd_block();
            b[0] = 1'b1; b[1] = p[0]; b[6] = p[1]; b[7] = p[2]; b[9] = p[3];
            b = seal(b);
            freq = p[1:0];
            send(b, 0, 191);
            look(1'b1, v); chk("R8 R6 pro", v, {1'b0, exp_fields(b, 1'b0)});
            look(1'b0, v); chk("R9 errview", v, {1'b0, 1'b1, p[1:0], 3'b111});
        end

        // R2: each received check bit flipped
        for (int k = 0; k < 8; k++) begin
            b = rnd_block();
            b[0] = 1'b1;
            b = seal(b);
            b[184+k] = ~b[184+k];
            send(b, 0, 191);
            look(1'b1, v); chk("R2 pro crc pin", {1'b0, v[5], 5'd0}, 7'b0);
            look(1'b0, v); chk("R2 errview", {1'b0, v[5], 2'b0, v[2:0]}, {1'b0, 1'b1, 2'b0, 3'b110});
        end
        b = seal(rnd_block()); b[0] = 1'b1; b = seal(b);
        send(b, 0, 191);
        look(1'b0, v); chk("R9 clean clears", {1'b0, 3'b0, v[2:0]}, 7'b0_000111);
        prev = b;

        // R3: early start
        b = seal(rnd_block());
        send(b, 0, 49);
        b = rnd_block(); b[0] = 1'b0; b = seal(b);
        send(b, 0, 0);
        look(1'b0, v); chk("R3 early start", {v[6], 3'b0, v[2:0]}, 7'b1_000100);
        look(1'b1, v); chk("R5 R3 fields held", {1'b0, 1'b0, v[4:0]}, {2'b0, exp_fields(prev, 1'b0)} & 7'b0011111);
        send(b, 1, 191);
        look(1'b1, v); chk("R3 resync block", v, {1'b0, exp_fields(b, 1'b0)});
        look(1'b0, v); chk("R3 flags cleared", {1'b0, 3'b0, v[2:0]}, 7'b0_000111);

        // R4: missing start at index 0
        frame(1'b1, 1'b0);
        look(1'b0, v); chk("R4 missing start", {v[6], 3'b0, v[2:0]}, 7'b0_000000);
        for (int i = 0; i < 10; i++) frame(1'b0, 1'b0);
        look(1'b0, v); chk("R4 stays unlocked", {v[6], 3'b0, v[2:0]}, 7'b0_000000);
        b = rnd_block(); b[0] = 1'b1; b = seal(b);
        send(b, 0, 191);
        look(1'b1, v); chk("R4 relock", v, {1'b0, exp_fields(b, 1'b0)});

        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule